// File: doc/BRIEF.md
# Multi-Lane Symbol Scrambler

This block whitens the byte stream of an N-lane serial link before line encoding. Each lane carries one byte per clock, a flag that marks the byte as a control symbol, and an enable. Each lane keeps its own 16-bit linear feedback shift register (LFSR). A data byte is XORed with eight bits taken from that register. Control symbols are passed through unchanged. The same module placed on the receive side undoes the scrambling, because the XOR mask depends only on the register state and that state evolves the same way at both ends.

Two special symbols steer the register. The comma symbol reloads it to all ones, which gives both ends a common starting point. The skip symbol freezes it, so that skip symbols can be added or removed along the path without losing step. Three other conditions suppress scrambling while the register keeps running. These are a global disable pin, a flag that marks the bytes as belonging to a control-type packet, and any non-data symbol. A one-shot input marks the exit from link training; the next frame after it is sent without advancing the register. Results are registered, with a latency of one cycle.

Top module: `lane_scrambler`

## Requirements
- R1: After reset, every output is zero and each lane's register holds 16'hFFFF.
- R2: A data byte (k flag low) on an enabled lane leaves the block one cycle later XORed with a mask. Mask bit i (LSB first) is bit 15 of the register before shift step i. Each step shifts left and, if the bit shifted out is 1, XORs 16'h0039 into the result (polynomial x^16+x^5+x^4+x^3+1). The register ends the cycle 8 steps on.
- R3: The comma symbol (k flag high, byte 8'hBC) passes unchanged with its k flag, and it reloads the lane register to 16'hFFFF.
- R4: The skip symbol (k flag high, byte 8'h1C) passes unchanged, and the lane register keeps its value.
- R5: Any other control symbol passes unchanged with its k flag, and the register advances 8 steps.
- R6: While the control-packet input is high, data bytes pass unscrambled and the register advances 8 steps.
- R7: While the scramble-disable input is high, data bytes pass unscrambled and the register advances 8 steps.
- R8: A pulse on the training-exit input arms a hold. The next cycle in which any lane is enabled scrambles with the current registers but does not advance them, and then the hold clears. A comma symbol still reloads during that cycle.
- R9: A lane whose enable is low produces zero data, a zero k flag and a low valid one cycle later, and its register keeps its value.
- R10: Lanes are independent: a symbol on one lane never changes another lane's register.
- R11: A second instance fed with the first one's outputs returns the original byte stream. This holds for streams that mix comma, skip and data symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_en | input | LANES | Per-lane symbol present |
| din | input | 8*LANES | Input bytes, lane 0 in bits 7:0 |
| din_k | input | LANES | Per-lane control-symbol flag |
| scr_off | input | 1 | Disable scrambling of data bytes |
| ctl_pkt | input | 1 | Current bytes belong to a control-type packet |
| train_exit | input | 1 | One-cycle pulse at exit from link training |
| dout | output | 8*LANES | Scrambled (or passed) bytes |
| dout_k | output | LANES | Registered control flag |
| dout_vld | output | LANES | Registered lane enable |

## Verification
A wrong register state does not show on a control symbol; it shows on the next data byte on that lane, one cycle after that byte enters. A lost reload, a skip that advances, or a missed training hold all corrupt every following data byte on the lane until the next comma. The comma itself repairs the state, so each check sends data directly after the symbol under test, and the bench compares against a model register kept per lane. The loop-back test shows the same faults as corrupted bytes out of the second instance two cycles later.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam logic [7:0]  SYM_COMMA = 8'hBC;
  localparam logic [7:0]  SYM_SKIP  = 8'h1C;
  localparam logic [15:0] SEED      = 16'hFFFF;
  localparam int          STEPS     = 8;
endpackage

// File: rtl/scr_lfsr_step.sv
module scr_lfsr_step
  import scr_pkg::*;
(
  input  logic [15:0]      state,
  output logic [STEPS-1:0] mask,
  output logic [15:0]      next
);
  logic [15:0] chain [0:STEPS];

  assign chain[0] = state;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    logic fb;
    assign fb           = chain[i][15];
    assign mask[i]      = fb;
    assign chain[i+1]   = {chain[i][14:0], 1'b0} ^ {10'b0, fb, fb, fb, 2'b0, fb};
  end

  assign next = chain[STEPS];
endmodule

// File: rtl/scr_train_hold.sv
module scr_train_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic train_exit,
  input  logic any_en,
  output logic hold_adv
);
  logic pending;

  assign hold_adv = pending & any_en;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= train_exit | (pending & ~any_en);
  end
endmodule

// File: rtl/scr_lane.sv
module scr_lane
  import scr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [7:0]  din,
  input  logic        din_k,
  input  logic        scr_off,
  input  logic        ctl_pkt,
  input  logic        hold_adv,
  output logic [7:0]  dout,
  output logic        dout_k,
  output logic        dout_vld,
  output logic [15:0] lfsr_q,
  output logic        adv
);
  logic [7:0]  mask;
  logic [15:0] lfsr_nx;
  logic        is_com, is_skp, pass;
  logic [15:0] lfsr_d;
  logic [7:0]  byte_d;

  scr_lfsr_step u_step (.state(lfsr_q), .mask(mask), .next(lfsr_nx));

  assign is_com = en & din_k & (din == SYM_COMMA);
  assign is_skp = en & din_k & (din == SYM_SKIP);
  assign pass   = din_k | scr_off | ctl_pkt;
  assign adv    = en & ~is_com & ~is_skp & ~hold_adv;

  always_comb begin
    lfsr_d = lfsr_q;
    if (is_com)   lfsr_d = SEED;
    else if (adv) lfsr_d = lfsr_nx;
  end

  always_comb begin
    byte_d = '0;
    if (en) byte_d = pass ? din : (din ^ mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q   <= SEED;
      dout     <= '0;
      dout_k   <= 1'b0;
      dout_vld <= 1'b0;
    end else begin
      lfsr_q   <= lfsr_d;
      dout     <= byte_d;
      dout_k   <= en & din_k;
      dout_vld <= en;
    end
  end
endmodule

// File: rtl/lane_scrambler.sv
module lane_scrambler #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   lane_en,
  input  logic [8*LANES-1:0] din,
  input  logic [LANES-1:0]   din_k,
  input  logic               scr_off,
  input  logic               ctl_pkt,
  input  logic               train_exit,
  output logic [8*LANES-1:0] dout,
  output logic [LANES-1:0]   dout_k,
  output logic [LANES-1:0]   dout_vld
);
  localparam int SW = 16 * LANES;

  logic [SW-1:0]    lfsr_all;
  logic [LANES-1:0] adv_all;
  logic             hold_adv;

  scr_train_hold u_hold (
    .clk(clk), .rst_n(rst_n), .train_exit(train_exit),
    .any_en(|lane_en), .hold_adv(hold_adv)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    scr_lane u_lane (
      .clk(clk), .rst_n(rst_n), .en(lane_en[l]),
      .din(din[8*l +: 8]), .din_k(din_k[l]),
      .scr_off(scr_off), .ctl_pkt(ctl_pkt), .hold_adv(hold_adv),
      .dout(dout[8*l +: 8]), .dout_k(dout_k[l]), .dout_vld(dout_vld[l]),
      .lfsr_q(lfsr_all[16*l +: 16]), .adv(adv_all[l])
    );
  end
endmodule

// File: rtl/scr_checker.sv
module scr_checker
  import scr_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LANES-1:0]   lane_en,
  input logic [8*LANES-1:0] din,
  input logic [LANES-1:0]   din_k,
  input logic               scr_off,
  input logic [8*LANES-1:0] dout,
  input logic [LANES-1:0]   dout_k,
  input logic [LANES-1:0]   dout_vld,
  input logic [16*LANES-1:0] lfsr_all,
  input logic [LANES-1:0]   adv_all
);
  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R3: comma reloads the register
    assert_comma_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en[l] && din_k[l] && din[8*l +: 8] == SYM_COMMA) |=> lfsr_all[16*l +: 16] == SEED);
    // R4: skip freezes the register
    assert_skip_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en[l] && din_k[l] && din[8*l +: 8] == SYM_SKIP) |=> $stable(lfsr_all[16*l +: 16]));
    // R5: control symbols leave unchanged with their flag
    assert_ctrl_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en[l] && din_k[l]) |=> (dout[8*l +: 8] == $past(din[8*l +: 8]) && dout_k[l]));
    // R7: disable pin bypasses data
    assert_disable_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en[l] && scr_off) |=> dout[8*l +: 8] == $past(din[8*l +: 8]));
    // R9: idle lane gives zero output and a frozen register
    assert_idle_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en[l] |=> (!dout_vld[l] && !dout_k[l] && dout[8*l +: 8] == 8'h00
                       && $stable(lfsr_all[16*l +: 16])));
    // R2: an advance always moves a nonzero register
    assert_advance_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      adv_all[l] |=> lfsr_all[16*l +: 16] != 16'h0000);
  end
endmodule

bind lane_scrambler scr_checker #(.LANES(LANES)) u_scr_checker (
  .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .din(din), .din_k(din_k),
  .scr_off(scr_off), .dout(dout), .dout_k(dout_k), .dout_vld(dout_vld),
  .lfsr_all(lfsr_all), .adv_all(adv_all)
);

// File: tb/lane_scrambler_test.sv
module lane_scrambler_test;
  localparam int L = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [L-1:0]   lane_en = '0;
  logic [8*L-1:0] din = '0;
  logic [L-1:0]   din_k = '0;
  logic           scr_off = 1'b0, ctl_pkt = 1'b0, train_exit = 1'b0;
  logic [8*L-1:0] dout, rx_dout;
  logic [L-1:0]   dout_k, dout_vld, rx_k, rx_vld;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  lane_scrambler #(.LANES(L)) uut (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .din(din), .din_k(din_k),
    .scr_off(scr_off), .ctl_pkt(ctl_pkt), .train_exit(train_exit),
    .dout(dout), .dout_k(dout_k), .dout_vld(dout_vld)
  );

  lane_scrambler #(.LANES(L)) uut_rx (
    .clk(clk), .rst_n(rst_n), .lane_en(dout_vld), .din(dout), .din_k(dout_k),
    .scr_off(1'b0), .ctl_pkt(1'b0), .train_exit(1'b0),
    .dout(rx_dout), .dout_k(rx_k), .dout_vld(rx_vld)
  );

  // bench model of each lane register
  logic [15:0] st [L];
  bit          pend;
  logic [8*L-1:0] hist_d [2];

  function automatic logic [15:0] shift8(input logic [15:0] s);
    logic [15:0] t = s;
    for (int i = 0; i < 8; i++) t = {t[14:0], 1'b0} ^ (t[15] ? 16'h0039 : 16'h0000);
    return t;
  endfunction

  function automatic logic [7:0] whiten(input logic [15:0] s);
    logic [15:0] t = s;
    logic [7:0]  m;
    for (int i = 0; i < 8; i++) begin
      m[i] = t[15];
      t = {t[14:0], 1'b0} ^ (t[15] ? 16'h0039 : 16'h0000);
    end
    return m;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [8*L+2*L-1:0] act,
                       input logic [8*L+2*L-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check after the edge, update model
  task automatic go(input logic [L-1:0] en, input logic [8*L-1:0] d, input logic [L-1:0] k,
                    input bit byp, input bit ctl, input bit trn, input string tag);
    logic [8*L-1:0] ed;
    logic [L-1:0]   ek;
    bit hold;
    hold = pend && (|en);
    ed = '0; ek = '0;
    for (int l = 0; l < L; l++) begin
      if (en[l]) begin
        ek[l] = k[l];
        ed[8*l +: 8] = (k[l] || byp || ctl) ? d[8*l +: 8] : d[8*l +: 8] ^ whiten(st[l]);
      end
    end
    lane_en = en; din = d; din_k = k; scr_off = byp; ctl_pkt = ctl; train_exit = trn;
    @(posedge clk);
    #2;
    check(dout == ed && dout_k == ek && dout_vld == en, tag,
          {dout, dout_k, dout_vld}, {ed, ek, en});
    for (int l = 0; l < L; l++) begin
      if (en[l]) begin
        if (k[l] && d[8*l +: 8] == 8'hBC)      st[l] = 16'hFFFF;
        else if (k[l] && d[8*l +: 8] == 8'h1C) st[l] = st[l];
        else if (!hold)                        st[l] = shift8(st[l]);
      end
    end
    pend = trn || (pend && !(|en));
    hist_d[1] = hist_d[0];
    hist_d[0] = d;
    @(negedge clk);
  endtask

  localparam logic [L-1:0] ALL = '1;
  localparam logic [8*L-1:0] COMS = {L{8'hBC}};
  localparam logic [8*L-1:0] SKPS = {L{8'h1C}};

  task automatic t_reset;
    // R1: zero outputs, registers at all ones (seen through first data byte)
    check(dout == '0 && dout_k == '0 && dout_vld == '0, "R1 reset outputs",
          {dout, dout_k, dout_vld}, '0);
    go(ALL, 32'h00000000, '0, 0, 0, 0, "R1 first byte uses seed");
  endtask

  task automatic t_data;
    go(ALL, 32'hDEADBEEF, '0, 0, 0, 0, "R2 data pattern a");
    go(ALL, 32'hFFFFFFFF, '0, 0, 0, 0, "R2 data pattern b");
    go(ALL, 32'h0F1E2D3C, '0, 0, 0, 0, "R2 data pattern c");
  endtask

  task automatic t_comma;
    go(ALL, COMS, ALL, 0, 0, 0, "R3 comma passes");
    go(ALL, 32'h12345678, '0, 0, 0, 0, "R3 data after reload");
  endtask

  task automatic t_skip;
    go(ALL, 32'h11111111, '0, 0, 0, 0, "R4 data before skip");
    go(ALL, SKPS, ALL, 0, 0, 0, "R4 skip passes");
    go(ALL, SKPS, ALL, 0, 0, 0, "R4 second skip");
    go(ALL, 32'h22222222, '0, 0, 0, 0, "R4 data after skip");
  endtask

  task automatic t_kchar;
    go(ALL, {L{8'hFB}}, ALL, 0, 0, 0, "R5 other control symbol");
    go(ALL, 32'h33333333, '0, 0, 0, 0, "R5 data after control symbol");
  endtask

  task automatic t_ctl;
    go(ALL, 32'hA5A5A5A5, '0, 0, 1, 0, "R6 control packet data");
    go(ALL, 32'h44444444, '0, 0, 0, 0, "R6 data after control packet");
  endtask

  task automatic t_bypass;
    go(ALL, 32'h5A5A5A5A, '0, 1, 0, 0, "R7 disabled scrambling");
    go(ALL, 32'h55555555, '0, 0, 0, 0, "R7 data after disable");
  endtask

  task automatic t_train;
    go('0, '0, '0, 0, 0, 1, "R8 training exit pulse");
    go('0, '0, '0, 0, 0, 0, "R8 idle keeps hold armed");
    go(ALL, 32'h66666666, '0, 0, 0, 0, "R8 first frame no advance");
    go(ALL, 32'h66666666, '0, 0, 0, 0, "R8 same mask reused");
    go(ALL, 32'h77777777, '0, 0, 0, 0, "R8 hold cleared");
  endtask

  task automatic t_lanes;
    go(4'b0101, 32'h99887766, '0, 0, 0, 0, "R9 idle lanes 1 and 3");
    go(4'b1010, 32'h00000000, '0, 0, 0, 0, "R10 lanes 1 and 3 kept state");
    go(4'b0001, 32'h000000BC, 4'b0001, 0, 0, 0, "R10 comma on lane 0 only");
    go(ALL, 32'h00000000, '0, 0, 0, 0, "R10 other lanes unaffected");
  endtask

  task automatic t_loop;
    logic [8*L-1:0] pat [10];
    logic [L-1:0]   pk  [10];
    pat[0] = COMS;          pk[0] = ALL;
    pat[1] = 32'h01234567;  pk[1] = '0;
    pat[2] = 32'h89ABCDEF;  pk[2] = '0;
    pat[3] = SKPS;          pk[3] = ALL;
    pat[4] = 32'hCAFEF00D;  pk[4] = '0;
    pat[5] = COMS;          pk[5] = ALL;
    pat[6] = 32'h00FF00FF;  pk[6] = '0;
    pat[7] = 32'h1C1C0000;  pk[7] = 4'b1100;
    pat[8] = 32'h13579BDF;  pk[8] = '0;
    pat[9] = 32'h2468ACE0;  pk[9] = '0;
    for (int i = 0; i < 10; i++) begin
      go(ALL, pat[i], pk[i], 0, 0, 0, "R11 tx stage");
      if (i >= 2)
        check(rx_dout == hist_d[1] && rx_vld == ALL, "R11 loop-back",
              {rx_dout, rx_k, rx_vld}, {hist_d[1], pk[i-2], ALL});
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int l = 0; l < L; l++) st[l] = 16'hFFFF;
    pend = 0;
    hist_d[0] = '0; hist_d[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_data;
    t_comma;
    t_skip;
    t_kchar;
    t_ctl;
    t_bypass;
    t_train;
    t_lanes;
    t_loop;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule